// File: doc/BRIEF.md
# Word-serial RC6 block encryptor (16-bit words)

This block encrypts one 64-bit block with the RC6 cipher. It uses 16-bit words (w=16, lg w=4) and a parameterised round count r, which defaults to 20. A block is four words A, B, C and D.

The caller raises `start` for one cycle. From that cycle on it places one word on `din` in every cycle, with no gaps:
- four plaintext words, A first;
- then the 2r+4 externally expanded round keys, S[0] first.

The engine does not store the key schedule. Each key is used in the cycle it arrives:
- S[0] and S[1] whiten B and D;
- each later pair of keys completes one round, in two half-steps;
- the last two keys whiten A and C.

When the last key has been used, `ready` rises and the four ciphertext words appear on the outputs. They stay there until the next accepted start.

The controller is one state machine. Its states are:
- IDLE: after reset.
- LD_B, LD_C, LD_D: take plaintext words B, C and D.
- WH_B, WH_D: pre-whitening with S[0] and S[1].
- RND_A, RND_C: the two halves of a round.
- FIN_A, FIN_C: post-whitening.
- DONE: the result is presented.

Its transitions are:
- IDLE or DONE goes to LD_B on start; word A is captured on that edge.
- LD_B → LD_C → LD_D → WH_B → WH_D → RND_A.
- RND_A goes to RND_C.
- RND_C goes back to RND_A while rounds remain, or to FIN_A after round r.
- FIN_A goes to FIN_C, and FIN_C goes to DONE.
- Without start, IDLE and DONE stay where they are.

A round counter paces the RND_A/RND_C loop.

Top module: `rc6w_enc`

## Requirements
- R1: An asynchronous, active-high `rst` forces `ready` low and all four ciphertext outputs to zero at once, and returns the controller to IDLE.
- R2: A start seen while no block is in progress is accepted. `din` in that same cycle is plaintext word A. The next three cycles carry B, C and D. The 2r+4 cycles after those carry round keys S[0] to S[2r+3] in index order, one per cycle.
- R3: `ready` rises exactly 2r+8 cycles after the cycle of the accepted start, which is 48 cycles for r=20.
- R4: The outputs `ct_a`, `ct_b`, `ct_c` and `ct_d` are the final A, B, C and D of RC6 with 16-bit words, computed in this order:
  - Pre-whitening: B+=S[0] and D+=S[1].
  - Rounds i=1..r: t=rotl(B*(2B+1),4) and u=rotl(D*(2D+1),4). Then A=rotl(A^t,u[3:0])+S[2i] and C=rotl(C^u,t[3:0])+S[2i+1]. Then (A,B,C,D) becomes (B,C,D,A).
  - Post-whitening: A+=S[2r+2] and C+=S[2r+3].
  - All arithmetic is mod 2^16.
- R5: While `ready` is low, all four ciphertext outputs read zero.
- R6: Once high, `ready` and the ciphertext stay unchanged until a start is accepted. `ready` is low in the cycle after that start.
- R7: A start raised while a block is being loaded or processed is ignored: `din` in that cycle is still taken as the scheduled word, and the result and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin a block; `din` in this cycle is word A |
| din | input | W (16) | Plaintext word or round key, one per cycle |
| ready | output | 1 | Ciphertext valid |
| ct_a | output | W (16) | Ciphertext word A |
| ct_b | output | W (16) | Ciphertext word B |
| ct_c | output | W (16) | Ciphertext word C |
| ct_d | output | W (16) | Ciphertext word D |

## Verification
The bench aims at these corner cases, and at how a faulty design would show itself:
- All-zero and all-ones words. A wrong quadratic or rotate amount gives the wrong ciphertext; a bench-side decryption then fails to recover the plaintext.
- A start pulse partway through loading. A design that restarts would give a different ciphertext and raise `ready` late.
- A new start in the very cycle after `ready`. A design that accepts start only from IDLE would miss it.
- A reset partway through a block. A synchronous or incomplete reset would leave stale words or `ready` visible.
- Off-by-one key sequencing, such as a round-counter limit one off or a misplaced whitening key. This shows up as `ready` rising a cycle early or late, or as a mismatched result.

// File: rtl/rc6w_pkg.sv
package rc6w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LD_B,
        ST_LD_C,
        ST_LD_D,
        ST_WH_B,
        ST_WH_D,
        ST_RND_A,
        ST_RND_C,
        ST_FIN_A,
        ST_FIN_C,
        ST_DONE
    } rc6w_state_e;

    typedef enum logic [3:0] {
        OP_HOLD,
        OP_LD_A,
        OP_LD_B,
        OP_LD_C,
        OP_LD_D,
        OP_ADD_B,
        OP_ADD_D,
        OP_HALF_A,
        OP_HALF_C,
        OP_ADD_A,
        OP_ADD_C
    } rc6w_op_e;

endpackage

// File: rtl/rc6w_mix.sv
// Quadratic mixing: f(x) = rotl(x*(2x+1) mod 2^W, lg W)
module rc6w_mix #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] f
);
    localparam int LGW = $clog2(W);

    logic [W-1:0] odd;
    logic [W-1:0] prod;

    always_comb begin
        odd  = {x[W-2:0], 1'b1};
        prod = x * odd;
        f    = {prod[W-1-LGW:0], prod[W-1:W-LGW]};
    end
endmodule

// File: rtl/rc6w_ctrl.sv
module rc6w_ctrl
    import rc6w_pkg::*;
#(
    parameter int R = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output rc6w_op_e op,
    output logic     ready,
    output logic     busy
);
    localparam int RW = (R > 1) ? $clog2(R) : 1;
    localparam logic [RW-1:0] LAST_RND = RW'(R - 1);

    rc6w_state_e state, state_nx;
    logic [RW-1:0] rnd;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // round counter: cleared during pre-whitening, advanced per full round
    always_ff @(posedge clk or posedge rst) begin
        if (rst)                    rnd <= '0;
        else if (state == ST_WH_D)  rnd <= '0;
        else if (state == ST_RND_C) rnd <= rnd + 1'b1;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_LD_B;
            ST_LD_B:  state_nx = ST_LD_C;
            ST_LD_C:  state_nx = ST_LD_D;
            ST_LD_D:  state_nx = ST_WH_B;
            ST_WH_B:  state_nx = ST_WH_D;
            ST_WH_D:  state_nx = ST_RND_A;
            ST_RND_A: state_nx = ST_RND_C;
            ST_RND_C: state_nx = (rnd == LAST_RND) ? ST_FIN_A : ST_RND_A;
            ST_FIN_A: state_nx = ST_FIN_C;
            ST_FIN_C: state_nx = ST_DONE;
            ST_DONE:  if (start) state_nx = ST_LD_B;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        op    = OP_HOLD;
        ready = 1'b0;
        busy  = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) op = OP_LD_A;
            end
            ST_LD_B:  op = OP_LD_B;
            ST_LD_C:  op = OP_LD_C;
            ST_LD_D:  op = OP_LD_D;
            ST_WH_B:  op = OP_ADD_B;
            ST_WH_D:  op = OP_ADD_D;
            ST_RND_A: op = OP_HALF_A;
            ST_RND_C: op = OP_HALF_C;
            ST_FIN_A: op = OP_ADD_A;
            ST_FIN_C: op = OP_ADD_C;
            ST_DONE: begin
                busy  = 1'b0;
                ready = 1'b1;
                if (start) op = OP_LD_A;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/rc6w_dpath.sv
module rc6w_dpath
    import rc6w_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  rc6w_op_e     op,
    input  logic [W-1:0] din,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q,
    output logic [W-1:0] c_q,
    output logic [W-1:0] d_q
);
    localparam int LGW = $clog2(W);

    function automatic logic [W-1:0] rotv(input logic [W-1:0] v, input logic [LGW-1:0] s);
        rotv = (v << s) | (v >> (W - int'(s)));
    endfunction

    // mixing of B (index 0 -> t) and D (index 1 -> u)
    logic [W-1:0] mix_in  [2];
    logic [W-1:0] mix_out [2];

    assign mix_in[0] = b_q;
    assign mix_in[1] = d_q;

    for (genvar g = 0; g < 2; g++) begin : g_mix
        rc6w_mix #(.W(W)) u_mix (.x(mix_in[g]), .f(mix_out[g]));
    end

    logic [W-1:0] t_w, u_w, a_half, c_half;

    always_comb begin
        t_w    = mix_out[0];
        u_w    = mix_out[1];
        a_half = rotv(a_q ^ t_w, u_w[LGW-1:0]) + din;
        c_half = rotv(c_q ^ u_w, t_w[LGW-1:0]) + din;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= '0;
            d_q <= '0;
        end else begin
            unique case (op)
                OP_LD_A:   a_q <= din;
                OP_LD_B:   b_q <= din;
                OP_LD_C:   c_q <= din;
                OP_LD_D:   d_q <= din;
                OP_ADD_B:  b_q <= b_q + din;
                OP_ADD_D:  d_q <= d_q + din;
                OP_HALF_A: a_q <= a_half;
                OP_HALF_C: begin
                    a_q <= b_q;
                    b_q <= c_half;
                    c_q <= d_q;
                    d_q <= a_q;
                end
                OP_ADD_A:  a_q <= a_q + din;
                OP_ADD_C:  c_q <= c_q + din;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rc6w_enc.sv
module rc6w_enc #(
    parameter int W = 16,
    parameter int R = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] din,
    output logic         ready,
    output logic [W-1:0] ct_a,
    output logic [W-1:0] ct_b,
    output logic [W-1:0] ct_c,
    output logic [W-1:0] ct_d
);
    import rc6w_pkg::*;

    rc6w_op_e     op;
    logic         busy;
    logic [W-1:0] a_q, b_q, c_q, d_q;

    rc6w_ctrl #(.R(R)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .op(op), .ready(ready), .busy(busy)
    );

    rc6w_dpath #(.W(W)) u_dpath (
        .clk(clk), .rst(rst), .op(op), .din(din),
        .a_q(a_q), .b_q(b_q), .c_q(c_q), .d_q(d_q)
    );

    assign ct_a = ready ? a_q : '0;
    assign ct_b = ready ? b_q : '0;
    assign ct_c = ready ? c_q : '0;
    assign ct_d = ready ? d_q : '0;
endmodule

// File: rtl/rc6w_chk.sv
module rc6w_chk #(
    parameter int W = 16,
    parameter int R = 20
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         ready,
    input logic [W-1:0] ct_a,
    input logic [W-1:0] ct_b,
    input logic [W-1:0] ct_c,
    input logic [W-1:0] ct_d
);
    localparam int NLAT = 2 * R + 8;
    localparam int LW   = $clog2(NLAT + 2);
    localparam logic [LW-1:0] LAT_MAX = LW'(NLAT + 1);

    // cycles since the last accepted start (0 = none yet)
    logic [LW-1:0] lat;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                          lat <= '0;
        else if (start && !busy)          lat <= LW'(1);
        else if (lat != '0 && lat < LAT_MAX) lat <= lat + 1'b1;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy && !ready);

    // R3
    ready_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> lat == LW'(NLAT));

    // R5
    ct_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (ct_a == '0 && ct_b == '0 && ct_c == '0 && ct_d == '0));

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready && !start |=> ready && $stable(ct_a) && $stable(ct_b) && $stable(ct_c) && $stable(ct_d));

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ready && start |=> !ready);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        busy && start && lat != LW'(NLAT - 1) |=> busy);

    // R1
    always_comb begin
        if (rst) begin
            reset_out_chk: assert (!ready && ct_a == '0 && ct_b == '0 && ct_c == '0 && ct_d == '0);
        end
    end
endmodule

bind rc6w_enc rc6w_chk #(.W(W), .R(R)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .ready(ready),
    .ct_a(ct_a), .ct_b(ct_b), .ct_c(ct_c), .ct_d(ct_d)
);

// File: tb/sim_rc6w_enc.sv
module sim_rc6w_enc;
    localparam int CLK_P = 10;
    localparam int R     = 20;
    localparam int NK    = 2 * R + 4;
    localparam int NW    = NK + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] din = '0;
    logic        ready;
    logic [15:0] ct_a, ct_b, ct_c, ct_d;

    int errs = 0;
    int checks = 0;

    rc6w_enc #(.W(16), .R(R)) u0 (
        .clk(clk), .rst(rst), .start(start), .din(din),
        .ready(ready), .ct_a(ct_a), .ct_b(ct_b), .ct_c(ct_c), .ct_d(ct_d)
    );

    always #(CLK_P / 2) clk = ~clk;

    // ---------------- behavioural cipher model ----------------
    function automatic logic [15:0] rol(input logic [15:0] x, input int n);
        int k = n % 16;
        return (k == 0) ? x : ((x << k) | (x >> (16 - k)));
    endfunction

    function automatic logic [15:0] ror(input logic [15:0] x, input int n);
        return rol(x, (16 - (n % 16)) % 16);
    endfunction

    function automatic logic [15:0] quad(input logic [15:0] x);
        logic [31:0] p = 32'(x) * (32'(x) * 2 + 1);
        return rol(p[15:0], 4);
    endfunction

    logic [15:0] wq[$];
    logic [15:0] exp_ct [4];
    logic        exp_ready = 1'b0;
    int          pos = -1;

    task automatic model_encrypt();
        logic [15:0] A = wq[0], B = wq[1], C = wq[2], D = wq[3], t, u, x;
        B = B + wq[4];
        D = D + wq[5];
        for (int i = 1; i <= R; i++) begin
            t = quad(B);
            u = quad(D);
            A = rol(A ^ t, int'(u[3:0])) + wq[4 + 2 * i];
            C = rol(C ^ u, int'(t[3:0])) + wq[5 + 2 * i];
            x = A; A = B; B = C; C = D; D = x;
        end
        A = A + wq[4 + 2 * R + 2];
        C = C + wq[4 + 2 * R + 3];
        exp_ct[0] = A; exp_ct[1] = B; exp_ct[2] = C; exp_ct[3] = D;
    endtask

    // inverse cipher over the last captured key stream; returns plaintext
    task automatic model_decrypt(input logic [15:0] ci [4], output logic [15:0] po [4]);
        logic [15:0] A = ci[0], B = ci[1], C = ci[2], D = ci[3], t, u, x;
        C = C - wq[4 + 2 * R + 3];
        A = A - wq[4 + 2 * R + 2];
        for (int i = R; i >= 1; i--) begin
            x = D; D = C; C = B; B = A; A = x;
            u = quad(D);
            t = quad(B);
            C = ror(C - wq[5 + 2 * i], int'(t[3:0])) ^ u;
            A = ror(A - wq[4 + 2 * i], int'(u[3:0])) ^ t;
        end
        D = D - wq[5];
        B = B - wq[4];
        po[0] = A; po[1] = B; po[2] = C; po[3] = D;
    endtask

    // ---------------- checking ----------------
    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_cycle();
        logic [63:0] e;
        check("R3", "ready", 64'(ready), 64'(exp_ready));
        if (exp_ready) begin
            e = {exp_ct[0], exp_ct[1], exp_ct[2], exp_ct[3]};
            check("R4", "ciphertext", {ct_a, ct_b, ct_c, ct_d}, e); // also R6 hold
        end else begin
            check("R5", "ct while not ready", {ct_a, ct_b, ct_c, ct_d}, 64'h0);
        end
    endtask

    // one clock: compare the state left by the last edge, then drive the next inputs
    task automatic tick(input logic st, input logic [15:0] w);
        @(negedge clk);
        compare_cycle();
        start = st;
        din   = w;
        if (pos < 0) begin
            if (st) begin            // accepted start (R2)
                wq.delete();
                wq.push_back(w);
                pos = 1;
                exp_ready = 1'b0;
            end
        end else begin               // start ignored while busy (R7)
            wq.push_back(w);
            pos++;
            if (pos == NW) begin
                model_encrypt();
                exp_ready = 1'b1;
                pos = -1;
            end
        end
    endtask

    logic [15:0] blk [NW];
    int lcg = 1;

    task automatic fill(input int mode, input int seed);
        lcg = seed;
        for (int k = 0; k < NW; k++) begin
            if (mode == 0)      blk[k] = 16'h0000;
            else if (mode == 1) blk[k] = 16'hFFFF;
            else begin
                lcg = lcg * 1103515245 + 12345;
                blk[k] = lcg[23:8];
            end
        end
    endtask

    // feed one block; glitch_at > 0 raises start on that word index as well (R7)
    task automatic run_blk(input int glitch_at, input int idle_after);
        logic [15:0] ci [4];
        logic [15:0] po [4];
        tick(1'b1, blk[0]);
        for (int k = 1; k < NW; k++) tick(k == glitch_at, blk[k]);
        for (int k = 0; k < idle_after; k++) tick(1'b0, 16'hA5A5); // R6 hold with noise on din
        if (idle_after > 0) begin
            ci[0] = ct_a; ci[1] = ct_b; ci[2] = ct_c; ci[3] = ct_d;
            model_decrypt(ci, po);
            check("R4", "decrypt(ct) vs plaintext",
                  {po[0], po[1], po[2], po[3]}, {blk[0], blk[1], blk[2], blk[3]});
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        #(CLK_P * 2 + 1);
        check("R1", "ready in reset", 64'(ready), 64'h0);
        check("R1", "ct in reset", {ct_a, ct_b, ct_c, ct_d}, 64'h0);
        @(negedge clk);
        rst = 1'b0;

        tick(1'b0, 16'h1234);
        tick(1'b0, 16'h0000);

        fill(0, 0); run_blk(0, 3);          // all zero words (R2, R4)
        fill(1, 0); run_blk(0, 3);          // all ones
        fill(2, 7); run_blk(0, 2);          // pseudo-random
        fill(2, 99); run_blk(10, 2);        // R7: start during key load
        fill(2, 5); run_blk(2, 0);          // R7: start during plaintext load; no idle after
        fill(2, 31); run_blk(0, 2);         // R6: accepted straight from DONE

        // R1: asynchronous reset in the middle of a block
        fill(2, 77);
        tick(1'b1, blk[0]);
        for (int k = 1; k < 20; k++) tick(1'b0, blk[k]);
        @(negedge clk);
        compare_cycle();
        start = 1'b0;
        rst = 1'b1;
        #1;
        check("R1", "ready on async reset", 64'(ready), 64'h0);
        check("R1", "ct on async reset", {ct_a, ct_b, ct_c, ct_d}, 64'h0);
        pos = -1;
        exp_ready = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        tick(1'b0, 16'h0);
        fill(2, 123); run_blk(0, 3);        // clean block after reset

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule